// File: doc/BRIEF.md
# Prioritised Maskable Interrupt Recognizer

This block watches seven active-low interrupt request lines and decides, each clock, whether one of them is to be serviced. The decision uses the processor's current 3-bit priority mask. When it accepts a request, it emits a one-cycle acceptance pulse with the level that won. It also pushes the old mask onto a small internal stack and raises the mask to the accepted level. A return-from-exception pulse pops the stack and brings the earlier mask back. Software can overwrite the mask at any time through a dedicated write port.

Levels 1 to 6 are maskable and respond to the line being held low. Level 7 ignores the mask whenever the mask is below 7. When the mask already equals 7, a level-7 request is accepted again only on a new falling edge of its line. Every line passes through a synchroniser before any decision is made. The stack holds up to four saved masks, so nested service can be followed. A push onto a full stack sets an error flag.

Top module: `irq_recognizer`

## Requirements
- R1: A request line is synchronised through two register stages. A line driven low before clock edge k leads to an acceptance pulse that is visible after edge k+2, and to none before that edge.
- R2: A held request on levels 1 to 6 is accepted only when its level is strictly greater than the current mask. A request of equal or lower level stays unaccepted for as long as the mask does not drop.
- R3: When several eligible lines are low at once, the highest-numbered level is accepted. Line `irq_n[i]` carries level i+1.
- R4: Acceptance gives a one-cycle `take` pulse with `take_level` set to the accepted level. In the same edge, the old mask is pushed, `ipl` becomes the accepted level and `nest_depth` rises by one.
- R5: A `rte` pulse restores the most recently pushed mask and lowers `nest_depth` by one. With an empty stack, `rte` changes nothing.
- R6: A `mask_wr` pulse loads `mask_wr_val` into `ipl`. If the written value is below the level of a line that is still held low, that line is accepted again.
- R7: Level 7 is accepted while held whenever the mask is below 7. When the mask is 7, level 7 is accepted only on a fresh falling edge of its line, and the mask stays at 7.
- R8: Within one cycle, `rte` takes precedence over `mask_wr`, and `mask_wr` takes precedence over acceptance. In a cycle with either pulse, no request is accepted.
- R9: The stack holds 4 entries. An acceptance with 4 entries already stored still raises the mask and pulses `take`. In that case `nest_depth` stays at 4 and `overflow` is set, and it stays set until reset.
- R10: Reset, synchronous and active high, gives `ipl` = 7, `nest_depth` = 0, `take` = 0 and `overflow` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 7 | Active-low request lines, bit i is level i+1 |
| mask_wr | input | 1 | Software mask write strobe |
| mask_wr_val | input | 3 | Value written to the mask |
| rte | input | 1 | Return-from-exception pulse |
| take | output | 1 | One-cycle acceptance pulse |
| take_level | output | 3 | Accepted level, valid with `take` |
| ipl | output | 3 | Current priority mask |
| nest_depth | output | 3 | Number of saved masks on the stack |
| overflow | output | 1 | Sticky stack overflow flag |

## Verification
The first pattern is a single level-5 line against mask 3. It shows the synchroniser latency and the strict greater-than comparison. A second line at or below the raised mask checks that equal and lower levels stay blocked. A higher line arriving during service checks nesting. Two lines rising together check that the higher one wins. Return pulses in sequence, including one on an empty stack, check the stack order. A software write that lowers the mask while lines are held shows re-acceptance and its priority against `rte`. Level 7 is held, released and re-asserted against mask 7 and against mask 6. This separates edge acceptance from level acceptance, and repeated edges drive the stack into overflow.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int LEVELS = 7;
    localparam int LVL_W  = $clog2(LEVELS + 1);

    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic valid;
        lvl_t level;
    } grant_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_TAKE,
        OP_WRITE,
        OP_RETURN
    } mask_op_e;

    // Highest set bit of the eligibility vector, as a level number (bit i = level i+1).
    function automatic lvl_t top_level(input logic [LEVELS-1:0] elig);
        lvl_t r;
        r = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (elig[i]) r = lvl_t'(i + 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] irq_n,
    output logic [W-1:0] req
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= ~irq_n;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign req = stg[STAGES-1];
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic [LEVELS-1:0] req,
    input  logic              nmi_edge,
    input  lvl_t              ipl,
    output grant_t            grant
);
    logic [LEVELS-1:0] elig;

    for (genvar i = 0; i < LEVELS; i++) begin : g_elig
        localparam lvl_t LV = lvl_t'(i + 1);
        if (i == LEVELS - 1) begin : g_top
            // top level: level-sensitive below a full mask, edge-only at a full mask
            assign elig[i] = req[i] & ((LV > ipl) | nmi_edge);
        end else begin : g_mask
            assign elig[i] = req[i] & (LV > ipl);
        end
    end

    assign grant.valid = |elig;
    assign grant.level = top_level(elig);
endmodule

// File: rtl/irq_mask_stack.sv
module irq_mask_stack
    import irq_pkg::*;
#(
    parameter int   DEPTH      = 4,
    parameter lvl_t RESET_MASK = lvl_t'(LEVELS),
    localparam int  DW         = $clog2(DEPTH + 1),
    localparam int  IW         = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  mask_op_e      op,
    input  lvl_t          take_lvl,
    input  lvl_t          wr_val,
    output lvl_t          ipl,
    output logic [DW-1:0] depth,
    output logic          overflow
);
    lvl_t stk [DEPTH];

    wire full  = (depth == DW'(DEPTH));
    wire empty = (depth == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ipl      <= RESET_MASK;
            depth    <= '0;
            overflow <= 1'b0;
            for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
        end else begin
            unique case (op)
                OP_TAKE: begin
                    if (full) begin
                        overflow <= 1'b1;
                    end else begin
                        stk[IW'(depth)] <= ipl;
                        depth           <= depth + DW'(1);
                    end
                    ipl <= take_lvl;
                end
                OP_WRITE: ipl <= wr_val;
                OP_RETURN: begin
                    if (!empty) begin
                        ipl   <= stk[IW'(depth - DW'(1))];
                        depth <= depth - DW'(1);
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_recognizer.sv
module irq_recognizer
    import irq_pkg::*;
#(
    parameter int  STACK_DEPTH = 4,
    parameter int  SYNC_STAGES = 2,
    localparam int DW          = $clog2(STACK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEVELS-1:0] irq_n,
    input  logic              mask_wr,
    input  logic [LVL_W-1:0]  mask_wr_val,
    input  logic              rte,
    output logic              take,
    output logic [LVL_W-1:0]  take_level,
    output logic [LVL_W-1:0]  ipl,
    output logic [DW-1:0]     nest_depth,
    output logic              overflow
);
    logic [LEVELS-1:0] req;
    logic              top_prev;
    logic              nmi_edge;
    grant_t            grant;
    mask_op_e          op;

    irq_sync #(.W(LEVELS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .irq_n (irq_n),
        .req   (req)
    );

    always_ff @(posedge clk) begin
        if (rst) top_prev <= 1'b0;
        else     top_prev <= req[LEVELS-1];
    end
    assign nmi_edge = req[LEVELS-1] & ~top_prev;

    irq_arbiter u_arb (
        .req      (req),
        .nmi_edge (nmi_edge),
        .ipl      (ipl),
        .grant    (grant)
    );

    always_comb begin
        if (rte)              op = OP_RETURN;
        else if (mask_wr)     op = OP_WRITE;
        else if (grant.valid) op = OP_TAKE;
        else                  op = OP_NONE;
    end

    irq_mask_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .take_lvl (grant.level),
        .wr_val   (mask_wr_val),
        .ipl      (ipl),
        .depth    (nest_depth),
        .overflow (overflow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            take       <= 1'b0;
            take_level <= '0;
        end else begin
            take       <= (op == OP_TAKE);
            take_level <= grant.level;
        end
    end
endmodule

// File: rtl/irq_recognizer_chk.sv
module irq_recognizer_chk
    import irq_pkg::*;
#(
    parameter int  STACK_DEPTH = 4,
    localparam int DW          = $clog2(STACK_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             mask_wr,
    input logic [LVL_W-1:0] mask_wr_val,
    input logic             rte,
    input logic             take,
    input logic [LVL_W-1:0] take_level,
    input logic [LVL_W-1:0] ipl,
    input logic [DW-1:0]    nest_depth,
    input logic             overflow
);
    assert_take_above_mask_R2: assert property (@(posedge clk) disable iff (rst)
        take |-> (take_level > $past(ipl)) || (take_level == lvl_t'(LEVELS)));

    assert_take_sets_mask_R4: assert property (@(posedge clk) disable iff (rst)
        take |-> (ipl == take_level) && (take_level != '0));

    assert_take_pushes_R4: assert property (@(posedge clk) disable iff (rst)
        (take && ($past(nest_depth) < DW'(STACK_DEPTH))) |-> nest_depth == $past(nest_depth) + DW'(1));

    assert_return_pops_R5: assert property (@(posedge clk) disable iff (rst)
        (rte && nest_depth != '0) |=> nest_depth == $past(nest_depth) - DW'(1));

    assert_return_blocks_take_R8: assert property (@(posedge clk) disable iff (rst)
        rte |=> !take);

    assert_write_loads_R6: assert property (@(posedge clk) disable iff (rst)
        (mask_wr && !rte) |=> (ipl == $past(mask_wr_val)) && !take);

    assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    assert_depth_bound_R9: assert property (@(posedge clk) disable iff (rst)
        nest_depth <= DW'(STACK_DEPTH));
endmodule

bind irq_recognizer irq_recognizer_chk #(.STACK_DEPTH(STACK_DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mask_wr     (mask_wr),
    .mask_wr_val (mask_wr_val),
    .rte         (rte),
    .take        (take),
    .take_level  (take_level),
    .ipl         (ipl),
    .nest_depth  (nest_depth),
    .overflow    (overflow)
);

// File: tb/irq_recognizer_test.sv
module irq_recognizer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] irq_n = 7'h7f;
    logic       mask_wr = 1'b0;
    logic [2:0] mask_wr_val = '0;
    logic       rte = 1'b0;
    logic       take;
    logic [2:0] take_level;
    logic [2:0] ipl;
    logic [2:0] nest_depth;
    logic       overflow;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_recognizer uut (
        .clk(clk), .rst(rst), .irq_n(irq_n), .mask_wr(mask_wr),
        .mask_wr_val(mask_wr_val), .rte(rte), .take(take),
        .take_level(take_level), .ipl(ipl), .nest_depth(nest_depth),
        .overflow(overflow)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_ipl, m_take, m_lvl, m_ovf, best;
    int mstk[$];
    logic [6:0] h0, h1, seen;
    bit p7, e7;

    always @(posedge clk) begin
        if (rst) begin
            m_ipl = 7; m_take = 0; m_lvl = 0; m_ovf = 0;
            mstk.delete(); h0 = '0; h1 = '0; p7 = 0;
        end else begin
            seen = h1;
            e7 = seen[6] && !p7;
            m_take = 0;
            if (rte) begin
                if (mstk.size() > 0) m_ipl = mstk.pop_back();
            end else if (mask_wr) begin
                m_ipl = int'(mask_wr_val);
            end else begin
                best = 0;
                for (int l = 7; l >= 1; l--) begin
                    if (seen[l-1] && (l > m_ipl || (l == 7 && e7))) begin
                        best = l;
                        break;
                    end
                end
                if (best != 0) begin
                    if (mstk.size() == 4) m_ovf = 1;
                    else mstk.push_back(m_ipl);
                    m_ipl = best; m_take = 1; m_lvl = best;
                end
            end
            p7 = seen[6];
            h1 = h0;
            h0 = ~irq_n;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (!rst && !done) begin
            chk(int'(take) == m_take, "R4 model take", int'(take), m_take);
            if (m_take == 1) chk(int'(take_level) == m_lvl, "R3 model level", int'(take_level), m_lvl);
            chk(int'(ipl) == m_ipl, "R6 model mask", int'(ipl), m_ipl);
            chk(int'(nest_depth) == mstk.size(), "R5 model depth", int'(nest_depth), mstk.size());
            chk(int'(overflow) == m_ovf, "R9 model overflow", int'(overflow), m_ovf);
        end
        if (cycles > 20000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_mask(input int v);
        mask_wr = 1'b1; mask_wr_val = 3'(v);
        tick();
        mask_wr = 1'b0;
    endtask

    task automatic do_rte();
        rte = 1'b1;
        tick();
        rte = 1'b0;
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick();
        // R10 reset state
        chk(ipl == 3'd7, "R10 reset mask", int'(ipl), 7);
        chk(nest_depth == 0, "R10 reset depth", int'(nest_depth), 0);
        chk(!take && !overflow, "R10 reset take/overflow", int'(take) + int'(overflow), 0);

        wr_mask(3);
        chk(ipl == 3'd3, "R6 write mask", int'(ipl), 3);

        // R1 latency, R2 level 5 above mask 3
        irq_n[4] = 1'b0;
        tick(2);
        chk(!take, "R1 no early take", int'(take), 0);
        tick();
        chk(take && take_level == 3'd5, "R4 take level 5", int'(take_level), 5);
        chk(ipl == 3'd5 && nest_depth == 1, "R4 mask raised", int'(ipl), 5);
        tick();
        chk(!take, "R2 held request not retaken", int'(take), 0);

        // R2 equal/lower blocked
        irq_n[2] = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk(!take, "R2 equal or lower blocked", int'(take), 0);
        end

        // R6 lowering the mask re-accepts held request
        wr_mask(2);
        chk(ipl == 3'd2 && !take, "R6 lowered mask", int'(ipl), 2);
        tick();
        chk(take && take_level == 3'd5, "R6 re-accepted", int'(take_level), 5);
        chk(nest_depth == 2, "R6 depth", int'(nest_depth), 2);

        // nesting with level 6
        irq_n[5] = 1'b0;
        tick(3);
        chk(take && take_level == 3'd6 && nest_depth == 3, "R4 nested level 6", int'(take_level), 6);

        irq_n = 7'h7f;
        tick(4);
        do_rte();
        chk(ipl == 3'd5 && nest_depth == 2, "R5 pop to 5", int'(ipl), 5);
        do_rte();
        chk(ipl == 3'd2 && nest_depth == 1, "R5 pop to 2", int'(ipl), 2);
        do_rte();
        chk(ipl == 3'd3 && nest_depth == 0, "R5 pop to 3", int'(ipl), 3);
        do_rte();
        chk(ipl == 3'd3 && nest_depth == 0, "R5 empty return no effect", int'(ipl), 3);

        // R3 simultaneous levels 2 and 4
        wr_mask(1);
        irq_n[1] = 1'b0; irq_n[3] = 1'b0;
        tick(3);
        chk(take && take_level == 3'd4, "R3 highest wins", int'(take_level), 4);
        irq_n = 7'h7f;
        tick(4);
        do_rte();
        chk(ipl == 3'd1, "R5 restore 1", int'(ipl), 1);

        // R7 level 7 against mask 7
        wr_mask(7);
        irq_n[6] = 1'b0;
        tick(3);
        chk(take && take_level == 3'd7 && ipl == 3'd7, "R7 edge at mask 7", int'(take_level), 7);
        for (int i = 0; i < 6; i++) begin
            tick();
            chk(!take, "R7 held line at mask 7 not retaken", int'(take), 0);
        end
        irq_n[6] = 1'b1; tick(3);
        irq_n[6] = 1'b0; tick(3);
        chk(take && nest_depth == 2, "R7 fresh edge retaken", int'(nest_depth), 2);
        do_rte(); do_rte();
        chk(nest_depth == 0 && ipl == 3'd7, "R5 back to 7", int'(ipl), 7);
        wr_mask(6);
        tick();
        chk(take && take_level == 3'd7 && nest_depth == 1, "R7 level-held below 7", int'(take_level), 7);

        // R9 overflow with repeated edges
        for (int k = 0; k < 4; k++) begin
            irq_n[6] = 1'b1; tick(3);
            irq_n[6] = 1'b0; tick(3);
            chk(take == 1'b1, "R9 take on edge", int'(take), 1);
        end
        chk(overflow && nest_depth == 4, "R9 overflow set", int'(overflow), 1);
        tick(5);
        chk(overflow == 1'b1, "R9 overflow sticky", int'(overflow), 1);

        // R8 priority
        irq_n = 7'h7f;
        rst = 1'b1; tick(2); rst = 1'b0; tick();
        wr_mask(0);
        irq_n[2] = 1'b0;
        tick(2);
        rte = 1'b1; mask_wr = 1'b1; mask_wr_val = 3'd5;
        tick();
        rte = 1'b0; mask_wr = 1'b0;
        chk(!take && ipl == 3'd0, "R8 return beats write and take", int'(ipl), 0);
        tick();
        chk(take && take_level == 3'd3, "R8 take after pulses", int'(take_level), 3);
        wr_mask(0);
        chk(!take && ipl == 3'd0, "R8 write beats take", int'(ipl), 0);
        tick();
        chk(take && nest_depth == 2, "R8 take follows write", int'(nest_depth), 2);

        irq_n = 7'h7f;
        tick(3);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule